// File: doc/BRIEF.md
# Matrix Element Address Controller

This block sits between the matrix-operation sequencers of a numeric co-processor and the two RAMs that hold the working matrices. A sequencer asks for one element by naming a matrix (0 to 2), a row and a column, and says whether it is a read or a write. It never needs to know where that matrix physically lives. The upper layer holds a placement table with one descriptor per matrix. Each descriptor gives the row count, the column count (which is also the row stride), a split row, and a base address in each RAM. The upper layer turns the request into a RAM choice and a physical word address. Two lower-layer port controllers, one per RAM, then carry out the access.

Rows below a matrix's split row live in the dual-port RAM. The remaining rows live in the single-port RAM. With this rule, a matrix can sit wholly in one RAM or be divided between the two. The dual-port RAM's far side belongs to a slower bus clock domain and is outside this block.

Requests enter over a valid/ready port, and every accepted request returns exactly one response over a second valid/ready port. A request is taken only when the response slot will be free by the next cycle, so back-pressure on the response side stalls the request side directly.

Top module: `mtx_addr_ctrl`

## Requirements
- R1: While reset is held, rsp_valid is 0, req_ready is 1 and neither RAM is enabled.
- R2: A request is accepted in a cycle where req_valid and req_ready are both high. req_ready equals (not rsp_valid) or rsp_ready. A RAM enable is raised only in a cycle where a request is accepted.
- R3: Each accepted request gives exactly one response, with rsp_valid high in the cycle right after acceptance. Responses come back in request order.
- R4: The dual-port RAM is chosen when row < split. Its address is dp_base + row*cols + col, driven in the same cycle as acceptance.
- R5: The single-port RAM is chosen when row >= split. Its address is sp_base + (row - split)*cols + col, driven in the same cycle as acceptance.
- R6: At most one RAM enable is high in any cycle. For a write, that RAM's write strobe is high and its write data equals req_wdata.
- R7: Matrix code 3, row >= rows, or col >= cols is an error. The response then has rsp_err = 1 and rsp_rdata = 0, and neither RAM is touched, so no RAM word changes.
- R8: A valid read response carries the addressed word as it stood at acceptance, with rsp_err = 0. A valid write response carries zero data. Both RAMs have one-cycle read latency, and their read data is valid only in the cycle after the access.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_rdata and rsp_err stay unchanged.
- R10: The default placement table is as follows. Matrix 0 is 6x4 with split 6 and DP base 0, so it lies wholly in the DP RAM. Matrix 1 is 5x5 with split 0 and SP base 0, so it lies wholly in the SP RAM. Matrix 2 is 4x6 with split 2, DP base 24 and SP base 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_mtx | input | 2 | Matrix code, 0 to 2 valid |
| req_row | input | 4 | Element row |
| req_col | input | 4 | Element column |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Request was out of range |
| sp_en | output | 1 | Single-port RAM enable |
| sp_we | output | 1 | Single-port RAM write strobe |
| sp_addr | output | 6 | Single-port RAM address |
| sp_wdata | output | 32 | Single-port RAM write data |
| sp_rdata | input | 32 | Single-port RAM read data, one cycle latency |
| dp_en | output | 1 | Dual-port RAM enable, datapath side |
| dp_we | output | 1 | Dual-port RAM write strobe |
| dp_addr | output | 6 | Dual-port RAM address |
| dp_wdata | output | 32 | Dual-port RAM write data |
| dp_rdata | input | 32 | Dual-port RAM read data, one cycle latency |

## Verification
The hardest case to reach is a read response that stalls after the RAM's one-cycle data window has closed. The block must then serve the word from its own hold register and not from the RAM output. The bench RAM models drive a garbage pattern in every cycle without a read, so a wrong source shows up at once. The stimulus drops rsp_ready often and at random, so that stalls land on reads from both RAMs. Row and column values are drawn past each matrix's limits, and matrix code 3 is included. Together these hit the split-row boundary of matrix 2 and every error form.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int NUM_MTX = 3;
  localparam int MID_W   = 2;
  localparam int ROW_W   = 4;
  localparam int COL_W   = 4;
  localparam int SP_AW   = 6;
  localparam int DP_AW   = 6;
  localparam int DW      = 32;

  typedef struct packed {
    logic [ROW_W:0]     rows;
    logic [COL_W:0]     cols;
    logic [ROW_W:0]     split;
    logic [SP_AW-1:0]   sp_base;
    logic [DP_AW-1:0]   dp_base;
  } mdesc_t;

  function automatic mdesc_t mk_desc(int r, int c, int s, int spb, int dpb);
    mdesc_t d;
    d.rows    = (ROW_W+1)'(r);
    d.cols    = (COL_W+1)'(c);
    d.split   = (ROW_W+1)'(s);
    d.sp_base = SP_AW'(spb);
    d.dp_base = DP_AW'(dpb);
    return d;
  endfunction

  // element [2] first: matrix 2 split across both RAMs, matrix 1 SP only, matrix 0 DP only
  localparam mdesc_t [NUM_MTX-1:0] DEF_TABLE = {
    mk_desc(4, 6, 2, 25, 24),
    mk_desc(5, 5, 0, 0, 0),
    mk_desc(6, 4, 6, 0, 0)
  };
endpackage

// File: rtl/mtx_decode.sv
module mtx_decode
  import mtx_pkg::*;
(
  input  mdesc_t [NUM_MTX-1:0] tbl,
  input  logic [MID_W-1:0]     mtx,
  input  logic [ROW_W-1:0]     row,
  input  logic [COL_W-1:0]     col,
  output logic                 bad,
  output logic                 to_sp,
  output logic [SP_AW-1:0]     sp_addr,
  output logic [DP_AW-1:0]     dp_addr
);
  localparam int OW = ROW_W + COL_W + 2;

  mdesc_t         d;
  logic           id_ok;
  logic [OW-1:0]  lrow;
  logic [OW-1:0]  off;

  always_comb begin
    d     = '0;
    id_ok = 1'b0;
    for (int i = 0; i < NUM_MTX; i++) begin
      if (mtx == MID_W'(i)) begin
        d     = tbl[i];
        id_ok = 1'b1;
      end
    end
  end

  always_comb begin
    to_sp   = {1'b0, row} >= d.split;
    bad     = !id_ok || ({1'b0, row} >= d.rows) || ({1'b0, col} >= d.cols);
    lrow    = to_sp ? (OW'(row) - OW'(d.split)) : OW'(row);
    off     = lrow * OW'(d.cols) + OW'(col);
    sp_addr = d.sp_base + off[SP_AW-1:0];
    dp_addr = d.dp_base + off[DP_AW-1:0];
  end
endmodule

// File: rtl/mtx_ram_port.sv
module mtx_ram_port #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          rd_pend,
  output logic [DW-1:0] rd_data
);
  assign ram_en    = go;
  assign ram_we    = go && we;
  assign ram_addr  = addr;
  assign ram_wdata = wdata;
  assign rd_data   = ram_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= go && !we;
  end
endmodule

// File: rtl/mtx_addr_ctrl.sv
module mtx_addr_ctrl
  import mtx_pkg::*;
#(
  parameter mdesc_t [NUM_MTX-1:0] TABLE = DEF_TABLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MID_W-1:0]  req_mtx,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              sp_en,
  output logic              sp_we,
  output logic [SP_AW-1:0]  sp_addr,
  output logic [DW-1:0]     sp_wdata,
  input  logic [DW-1:0]     sp_rdata,
  output logic              dp_en,
  output logic              dp_we,
  output logic [DP_AW-1:0]  dp_addr,
  output logic [DW-1:0]     dp_wdata,
  input  logic [DW-1:0]     dp_rdata
);
  logic             bad, to_sp, acc;
  logic [SP_AW-1:0] sp_a;
  logic [DP_AW-1:0] dp_a;
  logic             sp_pend, dp_pend;
  logic [DW-1:0]    sp_d, dp_d, live;
  logic             err_q, held_q;
  logic [DW-1:0]    hold_q;

  mtx_decode u_dec (
    .tbl(TABLE), .mtx(req_mtx), .row(req_row), .col(req_col),
    .bad(bad), .to_sp(to_sp), .sp_addr(sp_a), .dp_addr(dp_a)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  mtx_ram_port #(.AW(SP_AW), .DW(DW)) u_sp (
    .clk(clk), .rst_n(rst_n), .go(acc && !bad && to_sp), .we(req_we),
    .addr(sp_a), .wdata(req_wdata), .ram_en(sp_en), .ram_we(sp_we),
    .ram_addr(sp_addr), .ram_wdata(sp_wdata), .ram_rdata(sp_rdata),
    .rd_pend(sp_pend), .rd_data(sp_d)
  );

  mtx_ram_port #(.AW(DP_AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .go(acc && !bad && !to_sp), .we(req_we),
    .addr(dp_a), .wdata(req_wdata), .ram_en(dp_en), .ram_we(dp_we),
    .ram_addr(dp_addr), .ram_wdata(dp_wdata), .ram_rdata(dp_rdata),
    .rd_pend(dp_pend), .rd_data(dp_d)
  );

  // RAM data is only valid the cycle after the access
  always_comb begin
    if (sp_pend)      live = sp_d;
    else if (dp_pend) live = dp_d;
    else              live = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      err_q     <= 1'b0;
      held_q    <= 1'b0;
      hold_q    <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      err_q     <= bad;
      held_q    <= 1'b0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      held_q    <= 1'b0;
    end else if (rsp_valid && !held_q) begin
      held_q    <= 1'b1;
      hold_q    <= live;
    end
  end

  assign rsp_err   = err_q;
  assign rsp_rdata = held_q ? hold_q : live;
endmodule

// File: rtl/mtx_addr_ctrl_chk.sv
module mtx_addr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_mtx,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic       rsp_err,
  input logic       sp_en,
  input logic       dp_en
);
  assert_one_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp_en && dp_en));
  assert_en_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_en || dp_en) |-> (req_valid && req_ready));
  assert_ready_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  assert_rsp_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  assert_bad_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mtx == 2'd3) |-> !(sp_en || dp_en));
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

bind mtx_addr_ctrl mtx_addr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mtx(req_mtx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sp_en(sp_en), .dp_en(dp_en)
);

// File: tb/tb_mtx_addr_ctrl.sv
`timescale 1ns/1ps
module tb_mtx_addr_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_we = 0, rsp_ready = 0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [1:0]  req_mtx = 0;
  logic [3:0]  req_row = 0, req_col = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  logic        sp_en, sp_we, dp_en, dp_we;
  logic [5:0]  sp_addr, dp_addr;
  logic [31:0] sp_wdata, dp_wdata, sp_q, dp_q;

  always #10 clk = ~clk;

  mtx_addr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mtx(req_mtx), .req_row(req_row), .req_col(req_col), .req_we(req_we),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .sp_en(sp_en), .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata), .sp_rdata(sp_q),
    .dp_en(dp_en), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata), .dp_rdata(dp_q)
  );

  // RAM models: read data valid only one cycle, garbage otherwise
  logic [31:0] sp_mem [64];
  logic [31:0] dp_mem [64];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        sp_mem[i] <= 32'h5000_0000 + i;
        dp_mem[i] <= 32'hD000_0000 + i;
      end
      sp_q <= 32'hBAD0_0000;
      dp_q <= 32'hBAD1_0000;
    end else begin
      if (sp_en && sp_we) sp_mem[sp_addr] <= sp_wdata;
      if (dp_en && dp_we) dp_mem[dp_addr] <= dp_wdata;
      sp_q <= (sp_en && !sp_we) ? sp_mem[sp_addr] : 32'hBAD0_0000;
      dp_q <= (dp_en && !dp_we) ? dp_mem[dp_addr] : 32'hBAD1_0000;
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference placement (R10)
  int t_rows [3] = '{6, 5, 4};
  int t_cols [3] = '{4, 5, 6};
  int t_split[3] = '{6, 0, 2};
  int t_spb  [3] = '{0, 0, 25};
  int t_dpb  [3] = '{0, 0, 24};

  logic [31:0] ref_sp [64];
  logic [31:0] ref_dp [64];
  bit          m_valid = 0, m_err = 0;
  logic [31:0] m_data = 0;

  task automatic drive(bit v, int m, int r, int c, bit w, logic [31:0] wd, bit rr);
    req_valid = v; req_mtx = 2'(m); req_row = 4'(r); req_col = 4'(c);
    req_we = w; req_wdata = wd; rsp_ready = rr;
  endtask

  task automatic step();
    int m, r, c, a;
    bit ebad, esp, racc;
    m = int'(req_mtx); r = int'(req_row); c = int'(req_col);
    ebad = (m == 3) || (r >= t_rows[m % 3]) || (c >= t_cols[m % 3]);
    esp  = !ebad && (r >= t_split[m]);
    a = 0;
    if (!ebad) a = esp ? t_spb[m] + (r - t_split[m]) * t_cols[m] + c
                       : t_dpb[m] + r * t_cols[m] + c;
    racc = req_valid && (!m_valid || rsp_ready);
    check("R2 req_ready", 32'(req_ready), 32'(!m_valid || rsp_ready));
    check("R6/R7 sp_en", 32'(sp_en), 32'(racc && !ebad && esp));
    check("R6/R7 dp_en", 32'(dp_en), 32'(racc && !ebad && !esp));
    if (racc && !ebad && esp) begin
      check("R5 sp_addr", 32'(sp_addr), 32'(a));
      check("R6 sp_we", 32'(sp_we), 32'(req_we));
      if (req_we) check("R6 sp_wdata", sp_wdata, req_wdata);
    end
    if (racc && !ebad && !esp) begin
      check("R4 dp_addr", 32'(dp_addr), 32'(a));
      check("R6 dp_we", 32'(dp_we), 32'(req_we));
      if (req_we) check("R6 dp_wdata", dp_wdata, req_wdata);
    end
    check("R3 rsp_valid", 32'(rsp_valid), 32'(m_valid));
    if (m_valid) begin
      check("R7 rsp_err", 32'(rsp_err), 32'(m_err));
      check("R8/R9 rsp_rdata", rsp_rdata, m_data);
    end
    if (racc) begin
      m_valid = 1; m_err = ebad; m_data = 0;
      if (!ebad && !req_we) m_data = esp ? ref_sp[a] : ref_dp[a];
      if (!ebad && req_we) begin
        if (esp) ref_sp[a] = req_wdata; else ref_dp[a] = req_wdata;
      end
    end else if (rsp_ready) m_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      ref_sp[i] = 32'h5000_0000 + i;
      ref_dp[i] = 32'hD000_0000 + i;
    end
    repeat (3) @(negedge clk);
    #1;
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 ram enables", 32'({sp_en, dp_en}), 0);
    rst_n = 1;
    // directed: split boundary of matrix 2, errors, a stalled read
    @(negedge clk); drive(1, 2, 1, 5, 1, 32'hA1A1_0001, 1); #1 step();
    @(negedge clk); drive(1, 2, 2, 0, 1, 32'hB2B2_0002, 1); #1 step();
    @(negedge clk); drive(1, 2, 1, 5, 0, 0, 1); #1 step();
    @(negedge clk); drive(1, 2, 2, 0, 0, 0, 0); #1 step();
    @(negedge clk); drive(1, 3, 0, 0, 1, 32'hFFFF_FFFF, 0); #1 step();
    @(negedge clk); drive(1, 3, 0, 0, 1, 32'hFFFF_FFFF, 0); #1 step();
    @(negedge clk); drive(1, 1, 4, 5, 1, 32'hEEEE_EEEE, 1); #1 step();
    @(negedge clk); drive(1, 0, 6, 0, 1, 32'hEEEE_EEEE, 1); #1 step();
    @(negedge clk); drive(1, 1, 4, 4, 0, 0, 1); #1 step();
    @(negedge clk); drive(0, 0, 5, 3, 0, 0, 1); #1 step();
    // random traffic with frequent back-pressure
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      drive(($urandom % 4) != 0, $urandom % 4, $urandom % 8, $urandom % 8,
            $urandom % 2, $urandom, ($urandom % 10) < 6);
      #1 step();
    end
    // read back every matrix element to see errors left no mark (R7)
    for (int m = 0; m < 3; m++)
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++) begin
          @(negedge clk); drive(1, m, r, c, 0, 0, 1); #1 step();
        end
    @(negedge clk); drive(0, 0, 0, 0, 0, 0, 1); #1 step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule